// File: doc/BRIEF.md
# Modular Adder Self-Test Harness

This block exercises an adder for the residue modulus m = 2^N - 2^K - 1 (239 with the default N = 8, K = 4). The adder under test sits outside the harness. The harness drives the adder's two operand inputs and reads its result back on `sum_in`. Two 8-bit linear-feedback shift registers produce the pseudo-random operands. Any register value at or above m is brought into range by subtracting m once. An internal reference works out the correct modular sum for each pattern and compares it with what the adder returns in the same cycle.

A controller with three states runs the test: `ST_IDLE`, `ST_RUN` and `ST_DONE`. A `start` pulse in `ST_IDLE` or `ST_DONE` reloads both registers with their seeds, clears the verdict and latches `pat_count`. The controller then takes one of two transitions. It goes `ST_IDLE/ST_DONE -> ST_RUN` when the count is non-zero, and `ST_IDLE/ST_DONE -> ST_DONE` at once when the count is zero. `ST_RUN` applies one pattern per clock. On the clock of the last pattern it takes `ST_RUN -> ST_DONE`. `ST_DONE` holds until the next `start`. Reset returns the controller to `ST_IDLE`.

The verdict is a sticky `fail` flag. With it comes `fail_idx`, the zero-based number of the first pattern whose result disagreed.

Top module: `modadd_selftest`

## Requirements
- R1: After reset, busy, done and fail are 0 and fail_idx is 0.
- R2: A start accepted in ST_IDLE or ST_DONE with pat_count = P > 0 raises busy on the next cycle for exactly P cycles. Then done rises and stays high until the next start.
- R3: Operand A comes from an 8-bit register seeded 8'h01 and operand B from one seeded 8'hA5. Each step shifts the register left by one, and the new bit 0 is the XOR of bits 7, 5, 4 and 3. Pattern i uses the register values after i steps. Neither register is ever all-zero.
- R4: A register value v >= m is applied as v - m, so op_a and op_b are always below m (239 by default).
- R5: In every busy cycle, sum_in is compared with (op_a + op_b) when that sum is below m, and with (op_a + op_b - m) otherwise. Any disagreement sets fail.
- R6: Once set, fail stays high until the next accepted start. fail_idx holds the index, counted from 0, of the first disagreeing pattern.
- R7: When every pattern agrees, fail is 0 and fail_idx is 0 when done rises.
- R8: A start with pat_count = 0 goes straight to ST_DONE on the next cycle, with busy never high and fail 0.
- R9: start is ignored while busy. The run keeps its pattern sequence and its length.
- R10: An accepted start clears fail and fail_idx left over from a previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the block is not busy |
| pat_count | input | CNT_W | Number of patterns in the run, latched at start |
| op_a | output | N | Operand A driven to the adder under test |
| op_b | output | N | Operand B driven to the adder under test |
| sum_in | input | N | Result returned by the adder under test |
| busy | output | 1 | High in ST_RUN |
| done | output | 1 | High in ST_DONE |
| fail | output | 1 | Sticky mismatch flag |
| fail_idx | output | CNT_W | Index of the first mismatching pattern |

## Verification
The hardest situation to reach from the ports is a disagreement that appears only after the run is well under way, since a correct adder never gives one. The bench places a behavioural adder on the operand and result ports. It can run that adder in two faulty modes. In one mode the adder leaves out the wrap-around subtraction. In the other it forces bit 0 of the result to zero. Either fault shows up only on some operand pairs. The bench replays both registers on its own to predict which pattern index fails first, and then checks that later failures leave that index untouched.

// File: rtl/modadd_bist_pkg.sv
package modadd_bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bist_state_t;

    // modulus of the form 2^n - 2^k - 1
    function automatic int unsigned residue_modulus(input int unsigned n, input int unsigned k);
        return (32'd1 << n) - (32'd1 << k) - 32'd1;
    endfunction

endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
    parameter int unsigned        WIDTH = 8,
    parameter logic [WIDTH-1:0]   TAPS  = 8'hB8,
    parameter logic [WIDTH-1:0]   SEED  = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [WIDTH-1:0] q
);

    logic feedback;

    assign feedback = ^(q & TAPS);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            q <= SEED;
        end else if (step) begin
            q <= {q[WIDTH-2:0], feedback};
        end
    end

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        q != '0);

endmodule

// File: rtl/bist_modref.sv
module bist_modref #(
    parameter int unsigned N = 8,
    parameter int unsigned K = 4
) (
    input  logic [N-1:0] raw_a,
    input  logic [N-1:0] raw_b,
    output logic [N-1:0] op_a,
    output logic [N-1:0] op_b,
    output logic [N-1:0] expect_sum
);
    import modadd_bist_pkg::*;

    localparam int unsigned MOD_INT = residue_modulus(N, K);
    localparam logic [N:0]  MOD     = MOD_INT[N:0];

    logic [N:0] sum_raw;

    function automatic logic [N-1:0] fold(input logic [N-1:0] v);
        logic [N:0] w;
        w = {1'b0, v};
        if (w >= MOD) begin
            w = w - MOD;
        end
        return w[N-1:0];
    endfunction

    always_comb begin
        op_a    = fold(raw_a);
        op_b    = fold(raw_b);
        sum_raw = {1'b0, op_a} + {1'b0, op_b};
        if (sum_raw >= MOD) begin
            expect_sum = sum_raw[N-1:0] - MOD[N-1:0];
        end else begin
            expect_sum = sum_raw[N-1:0];
        end
    end

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pat_count,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] pat_idx
);
    import modadd_bist_pkg::*;

    bist_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic             last_pat;

    assign last_pat = (idx_q == cnt_q - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pattern counter and latched length
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            cnt_q <= pat_count;
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                done = (state_q == ST_DONE);
                if (start) begin
                    load    = 1'b1;
                    state_d = (pat_count == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                busy = 1'b1;
                step = 1'b1;
                if (last_pat) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pat_idx = idx_q;

    // R8
    zero_len_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && pat_count == '0) |=> (done && !busy));

    // R2
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_pat) |=> (busy && idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/modadd_selftest.sv
module modadd_selftest #(
    parameter int unsigned N      = 8,
    parameter int unsigned K      = 4,
    parameter int unsigned CNT_W  = 16,
    parameter logic [N-1:0] TAPS   = 8'hB8,
    parameter logic [N-1:0] SEED_A = 8'h01,
    parameter logic [N-1:0] SEED_B = 8'hA5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pat_count,
    output logic [N-1:0]     op_a,
    output logic [N-1:0]     op_b,
    input  logic [N-1:0]     sum_in,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [CNT_W-1:0] fail_idx
);
    import modadd_bist_pkg::*;

    localparam int unsigned MOD_INT = residue_modulus(N, K);
    localparam logic [N:0]  MOD     = MOD_INT[N:0];

    logic             load, step;
    logic [N-1:0]     raw_a, raw_b;
    logic [N-1:0]     expect_sum;
    logic [CNT_W-1:0] pat_idx;
    logic             mismatch;

    bist_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pat_count (pat_count),
        .load      (load),
        .step      (step),
        .busy      (busy),
        .done      (done),
        .pat_idx   (pat_idx)
    );

    bist_lfsr #(.WIDTH(N), .TAPS(TAPS), .SEED(SEED_A)) u_lfsr_a (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (step),
        .q    (raw_a)
    );

    bist_lfsr #(.WIDTH(N), .TAPS(TAPS), .SEED(SEED_B)) u_lfsr_b (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (step),
        .q    (raw_b)
    );

    bist_modref #(.N(N), .K(K)) u_ref (
        .raw_a      (raw_a),
        .raw_b      (raw_b),
        .op_a       (op_a),
        .op_b       (op_b),
        .expect_sum (expect_sum)
    );

    assign mismatch = busy && (sum_in != expect_sum);

    // sticky verdict with first-failure index
    always_ff @(posedge clk) begin
        if (rst || load) begin
            fail     <= 1'b0;
            fail_idx <= '0;
        end else if (mismatch && !fail) begin
            fail     <= 1'b1;
            fail_idx <= pat_idx;
        end
    end

    // R4
    operand_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ({1'b0, op_a} < MOD && {1'b0, op_b} < MOD));

    // R6
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !load) |=> (fail && $stable(fail_idx)));

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (!fail && fail_idx == '0));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !fail));

endmodule

// File: tb/modadd_selftest_bench.sv
module modadd_selftest_bench;

    localparam int MODV = 239;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pat_count = '0;
    logic [7:0]  op_a, op_b;
    logic [7:0]  sum_in;
    logic        busy, done, fail;
    logic [15:0] fail_idx;

    int fault_mode = 0;
    int n_tests = 0;
    int n_fail = 0;
    int busy_cnt = 0;
    int cycles = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    modadd_selftest u_modadd_selftest (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pat_count (pat_count),
        .op_a      (op_a),
        .op_b      (op_b),
        .sum_in    (sum_in),
        .busy      (busy),
        .done      (done),
        .fail      (fail),
        .fail_idx  (fail_idx)
    );

    function automatic logic [7:0] good_add(input logic [7:0] a, input logic [7:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s >= MODV) s = s - MODV;
        return s[7:0];
    endfunction

    function automatic logic [7:0] bench_add(input logic [7:0] a, input logic [7:0] b, input int mode);
        logic [7:0] r;
        r = good_add(a, b);
        if (mode == 1) r = a + b;
        if (mode == 2) r = {r[7:1], 1'b0};
        return r;
    endfunction

    function automatic logic [7:0] fold(input logic [7:0] v);
        return (int'(v) >= MODV) ? v - 8'(MODV) : v;
    endfunction

    function automatic logic [7:0] adv(input logic [7:0] q);
        return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
    endfunction

    // behavioural adder under test
    always_comb sum_in = bench_add(op_a, op_b, fault_mode);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pop expected operand pairs as patterns appear
    always @(negedge clk) begin
        cycles++;
        if (!rst && busy) begin
            busy_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected pattern", busy_cnt, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({op_a, op_b} == e, "R3 operand pair", {op_a, op_b}, e);
                chk(int'(op_a) < MODV && int'(op_b) < MODV, "R4 operand range", {op_a, op_b}, MODV);
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // driver: predict the run, push expectations, launch and check the verdict
    task automatic run_test(input int cnt, input int mode, input bit poke_mid);
        logic [7:0] la, lb, a, b;
        bit efail;
        int eidx;
        la = 8'h01; lb = 8'hA5; efail = 0; eidx = 0;
        for (int i = 0; i < cnt; i++) begin
            a = fold(la); b = fold(lb);
            exp_q.push_back({a, b});
            if (!efail && bench_add(a, b, mode) != good_add(a, b)) begin
                efail = 1; eidx = i;
            end
            la = adv(la); lb = adv(lb);
        end
        fault_mode = mode;
        pat_count = 16'(cnt);
        busy_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (cnt == 0) begin
            // R8
            chk(done && !busy, "R8 zero-length done", {busy, done}, 1);
        end
        if (poke_mid) begin
            repeat (4) @(negedge clk);
            pat_count = 16'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int w = 0; w < 2000 && !done; w++) @(negedge clk);
        chk(busy_cnt == cnt, poke_mid ? "R9 run length" : "R2 busy cycles", busy_cnt, cnt);
        chk(exp_q.size() == 0, "R3 all patterns seen", exp_q.size(), 0);
        chk(fail == efail, efail ? "R5 mismatch flagged" : "R7 pass verdict", fail, efail);
        chk(int'(fail_idx) == eidx, efail ? "R6 first fail index" : "R7 index zero", fail_idx, eidx);
        repeat (3) @(negedge clk);
        chk(done && !busy, "R2 done held", done, 1);
        chk(int'(fail_idx) == eidx && fail == efail, "R6 verdict sticky", fail_idx, eidx);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fail && fail_idx == 0, "R1 reset state", {busy, done, fail}, 0);

        run_test(20, 0, 0);
        run_test(1, 0, 0);
        run_test(300, 0, 0);
        run_test(60, 1, 0);
        // R10: clean run after a failing one clears the verdict
        run_test(30, 0, 0);
        run_test(60, 2, 0);
        run_test(0, 0, 0);
        run_test(25, 0, 1);
        run_test(40, 1, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule